// File: doc/BRIEF.md
# Address-Region Access Histogram Controller

The block builds a histogram of bus traffic by address region. Each accepted transaction carries an address. The block shifts that address right by the programmed region size and uses the next six bits as an index into an internal array of 64 saturating 16-bit counters. Gating decides whether a transaction counts. It combines a selectable enable source, a mask of disable pins, an optional qualifier filter, and the state of the clearing sweep. The event pins are active-low, are driven asynchronously, and pass through two-flop synchronizers before gating uses them.

When a counter reaches the programmed maximum, a sticky status bit is set. A route field can drive that status onto one of four active-low event outputs. Software has two self-clearing actions. A zeroing sweep clears the counter array one entry per clock. A soft reset restores the auxiliary registers (the local enable and the maximum count) and leaves the control register and the array untouched.

The transaction input is a valid/ready stream. `txn_ready` is held high at all times, so the block never applies back-pressure. A transaction is taken on every clock in which `txn_valid` is high. A transaction that gating rejects, including one that arrives during the sweep, is accepted and then dropped. The register port is plain: a write takes effect on the clock edge, and the read data is combinational from the current state.

Top module: `region_hist_ctrl`

## Requirements
- R1: The counter index is `txn_addr[s+5:s]`, where s is 6, 12, 17, 23 or 28 for region codes 0 to 4 (ctrl[2:0]). Codes 5 to 7 behave as code 4. Counter i is read at register address 64+i.
- R2: The enable source is ctrl[6:4].
  - Codes 0 and 2 never count.
  - Code 1 counts while the local-enable bit (register 1, bit 0) is 1.
  - Code 3 always counts.
  - Codes 4 to 7 count while event pin 0 to 3, respectively, is active.
- R3: Event pins are active when low and take effect through a two-flop synchronizer. A pin change first affects gating at the third rising edge after it. No transaction counts while any pin selected by the disable mask ctrl[10:7] is active; mask bit k selects pin k.
- R4: When the filter bit ctrl[3] is 1, only transactions with `txn_qual` high count. When it is 0, `txn_qual` is ignored.
- R5: A counting transaction increments its counter only while the counter is below the maximum-count register (register 2, reset value 0xFFFF). The increment that makes the counter equal to the maximum sets the status bit ctrl[14].
- R6: The status bit is sticky. It is cleared by a control write with bit 14 equal to 0, or by a write to register 1 with bit 1 (sample start) equal to 1. A control write with bit 14 equal to 1 leaves it unchanged. A reach event in the same cycle as a clear leaves it set.
- R7: The route field ctrl[13:11] drives the status onto the event outputs. Codes 4 to 7 drive `ev_out_n[code-4]` low while the status is set. Any other code keeps all four outputs high.
- R8: Writing 1 to ctrl[16] starts a sweep that clears one counter per clock, from index 0 to index 63. ctrl[16] reads 1 until the last entry is cleared, which takes 64 cycles. Transactions that arrive during the sweep are not counted.
- R9: Writing 1 to ctrl[17] resets the local-enable bit to 0 and the maximum-count register to 0xFFFF one cycle later. It leaves ctrl[13:0] and all counters unchanged, and ctrl[17] then reads 0.
- R10: ctrl[15] is read-only and shows the `tmr_underflow` input.
- R11: After reset, the control register reads 0, all counters read 0 and `ev_out_n` is 4'hF. `txn_ready` is 1 in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txn_valid | input | 1 | Transaction present |
| txn_ready | output | 1 | Always high; the block never stalls the stream |
| txn_addr | input | ADDR_W | Transaction address |
| txn_qual | input | 1 | External event-select match used by the filter |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | IDX_W+1 | Register address: 0 control, 1 auxiliary, 2 maximum count, 64 and above counters |
| reg_wdata | input | 18 | Register write data |
| reg_rdata | output | 18 | Combinational read data for `reg_addr` |
| ev_in_n | input | 4 | Asynchronous active-low event pins |
| ev_out_n | output | 4 | Active-low status outputs |
| tmr_underflow | input | 1 | Timer underflow status shown at ctrl[15] |

## Verification
The assertions check on every cycle these properties:
- An active disable pin, or a running sweep, never lets a count through.
- A counter below the maximum steps by exactly one, and a counter at or above the maximum stays put.
- The sweep ends only after visiting the last index.
- The status holds until it is cleared.
- A routed output mirrors the status.
- A soft reset lands on the default values.

Only the bench's scenarios show the rest. These are the exact index for each region size, the three-edge latency of the pin synchronizers, clearing by sample start against clearing by control write, and transactions that are dropped during the sweep. They also show that a soft reset spares the control fields and the counters. The bench's reference model tracks all of this cycle by cycle.

// File: rtl/hist_pkg.sv
package hist_pkg;
  localparam int N_EV   = 4;
  localparam int RW_W   = 18;
  localparam int B_STAT = 14;
  localparam int B_TMR  = 15;
  localparam int B_SWP  = 16;
  localparam int B_SRST = 17;
  localparam int B_SAMP = 1;

  typedef enum logic [2:0] {
    EN_OFF = 3'd0, EN_LOCAL = 3'd1, EN_RSVD = 3'd2, EN_ON = 3'd3,
    EN_PIN0 = 3'd4, EN_PIN1 = 3'd5, EN_PIN2 = 3'd6, EN_PIN3 = 3'd7
  } en_src_e;

  typedef struct packed {
    logic [2:0] route;
    logic [3:0] dis_mask;
    en_src_e    en_src;
    logic       filt;
    logic [2:0] region;
  } hist_ctrl_t;

  function automatic int unsigned region_shift(input logic [2:0] code);
    case (code)
      3'd0:    return 6;
      3'd1:    return 12;
      3'd2:    return 17;
      3'd3:    return 23;
      default: return 28;
    endcase
  endfunction
endpackage

// File: rtl/hist_ev_sync.sv
module hist_ev_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_n,
  output logic [W-1:0] sync_n
);
  logic [W-1:0] stg1_q, stg2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1_q <= '1;
      stg2_q <= '1;
    end else begin
      stg1_q <= async_n;
      stg2_q <= stg1_q;
    end
  end

  assign sync_n = stg2_q;
endmodule

// File: rtl/hist_gate.sv
module hist_gate
  import hist_pkg::*;
(
  input  hist_ctrl_t      ctrl,
  input  logic            local_en,
  input  logic [N_EV-1:0] ev_act,
  input  logic            txn_valid,
  input  logic            txn_qual,
  input  logic            sweep_busy,
  output logic            inc_en
);
  logic src_on, blocked, qual_ok;

  always_comb begin
    case (ctrl.en_src)
      EN_LOCAL: src_on = local_en;
      EN_ON:    src_on = 1'b1;
      EN_PIN0, EN_PIN1, EN_PIN2, EN_PIN3:
                src_on = ev_act[ctrl.en_src[1:0]];
      default:  src_on = 1'b0;
    endcase
  end

  assign blocked = |(ctrl.dis_mask & ev_act);
  assign qual_ok = !ctrl.filt || txn_qual;
  assign inc_en  = txn_valid && src_on && !blocked && qual_ok && !sweep_busy;
endmodule

// File: rtl/hist_cnt_array.sv
module hist_cnt_array #(
  parameter int N_CNT = 64,
  parameter int CNT_W = 16,
  localparam int IDX_W = $clog2(N_CNT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_en,
  input  logic [IDX_W-1:0] inc_idx,
  input  logic [CNT_W-1:0] max_cnt,
  input  logic             sweep_start,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CNT_W-1:0] rd_data,
  output logic             sweep_busy,
  output logic             reach
);
  logic [CNT_W-1:0] cnt_q [N_CNT];
  logic [IDX_W-1:0] ptr_q;
  logic             busy_q;
  logic [CNT_W-1:0] cur;
  logic             room;

  assign cur   = cnt_q[inc_idx];
  assign room  = cur < max_cnt;
  assign reach = inc_en && room && ((cur + 1'b1) == max_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_CNT; i++) cnt_q[i] <= '0;
      ptr_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      if (sweep_start) begin
        busy_q <= 1'b1;
        ptr_q  <= '0;
      end else if (busy_q) begin
        cnt_q[ptr_q] <= '0;
        ptr_q        <= ptr_q + 1'b1;
        if (ptr_q == IDX_W'(N_CNT - 1)) busy_q <= 1'b0;
      end
      if (inc_en && room) cnt_q[inc_idx] <= cur + 1'b1;
    end
  end

  assign rd_data    = cnt_q[rd_idx];
  assign sweep_busy = busy_q;

  // R5: a counter below the maximum steps by exactly one
  a_r5_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_en && room && !sweep_start) |=> cnt_q[$past(inc_idx)] == $past(cur) + 1'b1);
  // R5: a counter at or above the maximum holds its value
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_en && !room && !sweep_start) |=> cnt_q[$past(inc_idx)] == $past(cur));
  // R8: the sweep finishes only after clearing the last index
  a_r8_sweep_full: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(ptr_q) == IDX_W'(N_CNT - 1));
endmodule

// File: rtl/region_hist_ctrl.sv
module region_hist_ctrl
  import hist_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int N_CNT  = 64,
  parameter int CNT_W  = 16,
  localparam int IDX_W = $clog2(N_CNT),
  localparam int REG_AW = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn_valid,
  output logic              txn_ready,
  input  logic [ADDR_W-1:0] txn_addr,
  input  logic              txn_qual,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [RW_W-1:0]   reg_wdata,
  output logic [RW_W-1:0]   reg_rdata,
  input  logic [N_EV-1:0]   ev_in_n,
  output logic [N_EV-1:0]   ev_out_n,
  input  logic              tmr_underflow
);
  localparam int CTRL_W = $bits(hist_ctrl_t);

  hist_ctrl_t       ctrl_q;
  logic             status_q, local_en_q, srst_pend_q;
  logic [CNT_W-1:0] max_q;
  logic [N_EV-1:0]  ev_sync_n, ev_act;
  logic             inc_en, sweep_busy, reach, clr;
  logic [IDX_W-1:0] inc_idx;
  logic [CNT_W-1:0] cnt_rd;
  logic [ADDR_W-1:0] addr_sh;
  logic             in_win, ctrl_wr, aux_wr, max_wr, sweep_start;

  assign in_win  = reg_addr[IDX_W];
  assign ctrl_wr = reg_we && !in_win && reg_addr[IDX_W-1:0] == IDX_W'(0);
  assign aux_wr  = reg_we && !in_win && reg_addr[IDX_W-1:0] == IDX_W'(1);
  assign max_wr  = reg_we && !in_win && reg_addr[IDX_W-1:0] == IDX_W'(2);
  assign sweep_start = ctrl_wr && reg_wdata[B_SWP];
  assign clr = (ctrl_wr && !reg_wdata[B_STAT]) || (aux_wr && reg_wdata[B_SAMP]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q      <= '0;
      status_q    <= 1'b0;
      srst_pend_q <= 1'b0;
      local_en_q  <= 1'b0;
      max_q       <= '1;
    end else begin
      if (ctrl_wr) ctrl_q <= hist_ctrl_t'(reg_wdata[CTRL_W-1:0]);
      srst_pend_q <= ctrl_wr && reg_wdata[B_SRST];
      status_q    <= reach || (status_q && !clr);
      if (srst_pend_q) begin
        local_en_q <= 1'b0;
        max_q      <= '1;
      end else begin
        if (aux_wr) local_en_q <= reg_wdata[0];
        if (max_wr) max_q      <= reg_wdata[CNT_W-1:0];
      end
    end
  end

  hist_ev_sync #(.W(N_EV)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_n(ev_in_n), .sync_n(ev_sync_n)
  );
  assign ev_act = ~ev_sync_n;

  hist_gate u_gate (
    .ctrl(ctrl_q), .local_en(local_en_q), .ev_act(ev_act),
    .txn_valid(txn_valid), .txn_qual(txn_qual),
    .sweep_busy(sweep_busy), .inc_en(inc_en)
  );

  assign addr_sh = txn_addr >> region_shift(ctrl_q.region);
  assign inc_idx = addr_sh[IDX_W-1:0];

  hist_cnt_array #(.N_CNT(N_CNT), .CNT_W(CNT_W)) u_array (
    .clk(clk), .rst_n(rst_n), .inc_en(inc_en), .inc_idx(inc_idx),
    .max_cnt(max_q), .sweep_start(sweep_start),
    .rd_idx(reg_addr[IDX_W-1:0]), .rd_data(cnt_rd),
    .sweep_busy(sweep_busy), .reach(reach)
  );

  generate
    for (genvar k = 0; k < N_EV; k++) begin : g_route
      assign ev_out_n[k] = !(status_q && ctrl_q.route[2] && ctrl_q.route[1:0] == 2'(k));
    end
  endgenerate

  assign txn_ready = 1'b1;

  always_comb begin
    reg_rdata = '0;
    if (in_win) begin
      reg_rdata[CNT_W-1:0] = cnt_rd;
    end else begin
      case (reg_addr[IDX_W-1:0])
        IDX_W'(0): begin
          reg_rdata[CTRL_W-1:0] = ctrl_q;
          reg_rdata[B_STAT]     = status_q;
          reg_rdata[B_TMR]      = tmr_underflow;
          reg_rdata[B_SWP]      = sweep_busy;
          reg_rdata[B_SRST]     = srst_pend_q;
        end
        IDX_W'(1): reg_rdata[0] = local_en_q;
        IDX_W'(2): reg_rdata[CNT_W-1:0] = max_q;
        default:   reg_rdata = '0;
      endcase
    end
  end

  // R3: a selected active disable pin blocks counting
  a_r3_disable_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ctrl_q.dis_mask & ev_act)) |-> !inc_en);
  // R8: nothing counts while the sweep runs
  a_r8_no_count_in_sweep: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_busy |-> !inc_en);
  // R6: the status holds unless cleared
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q && !clr) |=> status_q);
  // R7: a routed output follows the status
  a_r7_route_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.route[2] |-> ($countones(~ev_out_n) == 32'(status_q)));
  // R7: at most one output is driven low
  a_r7_one_pin: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ev_out_n));
  // R9: soft reset restores the auxiliary defaults
  a_r9_aux_default: assert property (@(posedge clk) disable iff (!rst_n)
    srst_pend_q |=> (max_q == '1 && !local_en_q));
endmodule

// File: tb/region_hist_ctrl_bench.sv
module region_hist_ctrl_bench;
  localparam int ADDR_W = 40;
  localparam int NC = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        txn_valid = 1'b0, txn_qual = 1'b0, reg_we = 1'b0, tmr_underflow = 1'b0;
  logic        txn_ready;
  logic [ADDR_W-1:0] txn_addr = '0;
  logic [6:0]  reg_addr = '0;
  logic [17:0] reg_wdata = '0, reg_rdata;
  logic [3:0]  ev_in_n = 4'hF, ev_out_n;

  int compared = 0, mismatched = 0;
  bit done = 0;

  always #10 clk = ~clk;

  region_hist_ctrl u_region_hist_ctrl (
    .clk(clk), .rst_n(rst_n), .txn_valid(txn_valid), .txn_ready(txn_ready),
    .txn_addr(txn_addr), .txn_qual(txn_qual), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_in_n(ev_in_n),
    .ev_out_n(ev_out_n), .tmr_underflow(tmr_underflow)
  );

  // ---------------- reference model ----------------
  int m_cnt [NC];
  int m_max, m_ptr;
  bit m_local, m_status, m_busy, m_pend, m_filt;
  bit [2:0] m_reg, m_src, m_route;
  bit [3:0] m_mask, m_s1, m_s2;

  function automatic int shamt(input bit [2:0] c);
    case (c) 0: return 6; 1: return 12; 2: return 17; 3: return 23; default: return 28; endcase
  endfunction

  always @(posedge clk) begin : model
    bit [3:0] act; bit en, ok, reach, cwr, awr, mwr, clr; int idx;
    if (!rst_n) begin
      foreach (m_cnt[i]) m_cnt[i] = 0;
      m_max = 65535; m_ptr = 0; m_local = 0; m_status = 0; m_busy = 0; m_pend = 0;
      m_filt = 0; m_reg = 0; m_src = 0; m_route = 0; m_mask = 0; m_s1 = 4'hF; m_s2 = 4'hF;
    end else begin
      act = ~m_s2;
      case (m_src)
        1: en = m_local;
        3: en = 1;
        4, 5, 6, 7: en = act[m_src - 4];
        default: en = 0;
      endcase
      ok = txn_valid && en && ((m_mask & act) == 0) && (!m_filt || txn_qual) && !m_busy;
      reach = 0;
      if (ok) begin
        idx = int'((txn_addr >> shamt(m_reg)) & 40'd63);
        if (m_cnt[idx] < m_max) begin
          m_cnt[idx]++;
          if (m_cnt[idx] == m_max) reach = 1;
        end
      end
      cwr = reg_we && reg_addr == 0;
      awr = reg_we && reg_addr == 1;
      mwr = reg_we && reg_addr == 2;
      clr = (cwr && !reg_wdata[14]) || (awr && reg_wdata[1]);
      m_status = reach || (m_status && !clr);
      if (cwr && reg_wdata[16]) begin m_busy = 1; m_ptr = 0; end
      else if (m_busy) begin
        m_cnt[m_ptr] = 0;
        if (m_ptr == NC - 1) m_busy = 0; else m_ptr++;
      end
      if (m_pend) begin m_local = 0; m_max = 65535; end
      else begin
        if (awr) m_local = reg_wdata[0];
        if (mwr) m_max = int'(reg_wdata[15:0]);
      end
      m_pend = cwr && reg_wdata[17];
      if (cwr) {m_route, m_mask, m_src, m_filt, m_reg} = reg_wdata[13:0];
      m_s2 = m_s1; m_s1 = ev_in_n;
    end
  end

  function automatic logic [17:0] exp_rd(input logic [6:0] a);
    if (a >= 64) return 18'(m_cnt[a - 64]);
    case (a)
      0: return {m_pend, m_busy, tmr_underflow, m_status, m_route, m_mask, m_src, m_filt, m_reg};
      1: return {17'd0, m_local};
      2: return 18'(m_max);
      default: return '0;
    endcase
  endfunction

  function automatic logic [3:0] exp_ev();
    logic [3:0] v = 4'hF;
    if (m_status && m_route[2]) v[m_route[1:0]] = 1'b0;
    return v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #5;
    if (rst_n) begin
      chk("R11 ready", 32'(txn_ready), 32'd1);
      chk("R7 ev_out_n", 32'(ev_out_n), 32'(exp_ev()));
      chk(reg_addr >= 64 ? "R1 counter read" : "R9 register read",
          32'(reg_rdata), 32'(exp_rd(reg_addr)));
    end
  end

  // ---------------- driver tasks ----------------
  task automatic wr(input logic [6:0] a, input logic [17:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [17:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic burst(input logic [ADDR_W-1:0] a, input bit q, input int n);
    @(negedge clk); txn_valid = 1; txn_addr = a; txn_qual = q;
    repeat (n) @(negedge clk);
    txn_valid = 0; txn_qual = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [17:0] cw(input bit [2:0] rg, input bit f, input bit [2:0] src,
                                     input bit [3:0] msk, input bit [2:0] rt);
    return {1'b0, 1'b0, 1'b0, 1'b1, rt, msk, src, f, rg};
  endfunction

  function automatic logic [ADDR_W-1:0] at(input int idx, input int sh);
    return ADDR_W'(idx) << sh;
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL R11 watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin : stim
    logic [17:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11 reset state
    rd(0, d);  chk("R11 ctrl reset", 32'(d), 0);
    rd(64, d); chk("R11 counter reset", 32'(d), 0);
    chk("R11 ev_out reset", 32'(ev_out_n), 32'hF);
    chk("R11 ready", 32'(txn_ready), 1);
    // R2 disabled and reserved sources
    burst(at(0, 6), 0, 1);
    wr(0, cw(0, 0, 2, 0, 0)); burst(at(0, 6), 0, 1);
    rd(64, d); chk("R2 off/reserved no count", 32'(d), 0);
    // R1 region indexing
    wr(0, cw(0, 0, 3, 0, 0));
    burst(at(5, 6), 0, 3);
    burst(at(66, 6), 0, 1);
    rd(64 + 5, d); chk("R1 idx5 region0", 32'(d), 3);
    rd(64 + 2, d); chk("R1 index modulo 64", 32'(d), 1);
    wr(0, cw(1, 0, 3, 0, 0)); burst(at(7, 12) + 63, 0, 2);
    rd(64 + 7, d); chk("R1 region code1", 32'(d), 2);
    wr(0, cw(2, 0, 3, 0, 0)); burst(at(6, 17), 0, 1);
    rd(64 + 6, d); chk("R1 region code2", 32'(d), 1);
    wr(0, cw(3, 0, 3, 0, 0)); burst(at(4, 23), 0, 1);
    rd(64 + 4, d); chk("R1 region code3", 32'(d), 1);
    wr(0, cw(4, 0, 3, 0, 0)); burst(at(9, 28), 0, 1);
    rd(64 + 9, d); chk("R1 region code4", 32'(d), 1);
    wr(0, cw(5, 0, 3, 0, 0)); burst(at(10, 28), 0, 1);
    rd(64 + 10, d); chk("R1 reserved region code", 32'(d), 1);
    // R4 filter
    wr(0, cw(0, 1, 3, 0, 0));
    burst(at(11, 6), 0, 1);
    rd(64 + 11, d); chk("R4 filtered out", 32'(d), 0);
    burst(at(11, 6), 1, 1);
    rd(64 + 11, d); chk("R4 qualified", 32'(d), 1);
    // R2 local enable
    wr(0, cw(0, 0, 1, 0, 0)); burst(at(12, 6), 0, 1);
    rd(64 + 12, d); chk("R2 local off", 32'(d), 0);
    wr(1, 18'd1); burst(at(12, 6), 0, 1);
    rd(64 + 12, d); chk("R2 local on", 32'(d), 1);
    // R2 pin enable
    wr(0, cw(0, 0, 4, 0, 0));
    ev_in_n = 4'b1110; idle(3); burst(at(13, 6), 0, 1);
    ev_in_n = 4'hF; idle(3); burst(at(13, 6), 0, 1);
    wr(0, cw(0, 0, 7, 0, 0)); burst(at(13, 6), 0, 1);
    rd(64 + 13, d); chk("R2 pin enable", 32'(d), 1);
    // R3 disable mask and sync latency
    wr(0, cw(0, 0, 3, 4'b0100, 0));
    @(negedge clk); ev_in_n = 4'b1011; idle(3);
    burst(at(14, 6), 0, 1);
    rd(64 + 14, d); chk("R3 disabled by pin2", 32'(d), 0);
    @(negedge clk); ev_in_n = 4'hF; txn_valid = 1; txn_addr = at(14, 6);
    repeat (3) @(negedge clk); txn_valid = 0;
    rd(64 + 14, d); chk("R3 two-flop latency", 32'(d), 1);
    // R5 saturation and R7 routing
    wr(2, 18'd3);
    wr(0, cw(0, 0, 3, 0, 3'b110));
    burst(at(20, 6), 0, 5);
    rd(64 + 20, d); chk("R5 saturate at max", 32'(d), 3);
    rd(0, d); chk("R5 status set", 32'(d[14]), 1);
    chk("R7 routed to pin2", 32'(ev_out_n), 32'b1011);
    // R6 sticky and clears
    wr(0, cw(0, 0, 3, 0, 3'b110));
    rd(0, d); chk("R6 write 1 keeps status", 32'(d[14]), 1);
    wr(0, cw(0, 0, 3, 0, 3'b110) & ~18'(1 << 14));
    rd(0, d); chk("R6 write 0 clears", 32'(d[14]), 0);
    chk("R7 released", 32'(ev_out_n), 32'hF);
    burst(at(21, 6), 0, 3);
    wr(1, 18'd2);
    rd(0, d); chk("R6 sample start clears", 32'(d[14]), 0);
    wr(0, cw(0, 0, 3, 0, 3'b000));
    burst(at(22, 6), 0, 3);
    rd(0, d); chk("R6 set again", 32'(d[14]), 1);
    chk("R7 register-only route", 32'(ev_out_n), 32'hF);
    // R8 sweep
    burst(at(63, 6), 0, 1);
    wr(0, cw(0, 0, 3, 0, 0) | 18'(1 << 16));
    rd(0, d); chk("R8 busy reads 1", 32'(d[16]), 1);
    burst(at(30, 6), 0, 10);
    idle(70);
    rd(0, d);       chk("R8 bit self-clears", 32'(d[16]), 0);
    rd(64 + 5, d);  chk("R8 idx5 cleared", 32'(d), 0);
    rd(64 + 63, d); chk("R8 idx63 cleared", 32'(d), 0);
    rd(64 + 30, d); chk("R8 dropped during sweep", 32'(d), 0);
    // R9 soft reset
    wr(1, 18'd1);
    burst(at(40, 6), 0, 2);
    wr(0, cw(0, 0, 3, 0, 0) | 18'(1 << 17));
    idle(2);
    rd(2, d);      chk("R9 max default", 32'(d), 32'hFFFF);
    rd(1, d);      chk("R9 local cleared", 32'(d), 0);
    rd(0, d);      chk("R9 ctrl kept", 32'(d[13:0]), 32'(cw(0, 0, 3, 0, 0) & 18'h3FFF));
    chk("R9 bit self-clears", 32'(d[17]), 0);
    rd(64 + 40, d); chk("R9 array kept", 32'(d), 2);
    // R10 timer mirror
    tmr_underflow = 1; rd(0, d); chk("R10 mirror high", 32'(d[15]), 1);
    wr(0, cw(0, 0, 3, 0, 0)); 
    rd(0, d); chk("R10 not writable", 32'(d[15]), 1);
    tmr_underflow = 0; rd(0, d); chk("R10 mirror low", 32'(d[15]), 0);
    idle(3);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule